// File: doc/BRIEF.md
# Run-Time Depth-Selectable Page Table Walker

This block turns a 64-bit virtual address into a physical address by walking a radix tree of translation tables held in memory. Each table holds 512 entries of 64 bits, indexed by a 9-bit slice of the virtual address. A mode bit selects the depth of the tree at run time: four levels cover 48 virtual address bits and five levels cover 57. The canonical-form check on the incoming address widens with the mode.

A caller presents a request on a valid/ready stream. It gives the virtual address and the root table base. The walker accepts one request at a time. It holds `req_ready` low until it has presented the outcome for exactly one cycle on `rsp_valid`. The caller applies back-pressure simply by not raising `req_valid`. The result cannot be stalled. Table entries are fetched through a read port with a valid/ready request channel and a valid-only response channel. The port tolerates any number of stall cycles on either side. While a request is stalled, the walker holds its address steady.

The mode bit lives in an internal configuration register. It is written through `cfg_we`/`cfg_wdata`. A write is ignored while `long_mode` reports that 64-bit operation is active.

Top module: `pt_walk_unit`

## Requirements
- R1: After reset `lvl5_mode` is 0 (four levels). A cycle with `cfg_we` high and `long_mode` low loads `cfg_wdata[12]` into the mode bit, and `lvl5_mode` shows it from the next cycle on.
- R2: A cycle with `cfg_we` high while `long_mode` is high leaves the mode bit, and so the walk depth, unchanged.
- R3: In four-level mode an address whose bits 63:47 are not all equal completes with `rsp_fault_canon`=1, `rsp_fault_np`=0, `rsp_fault_level`=0, `rsp_paddr`=0 and no memory read.
- R4: In five-level mode the canonical check covers bits 63:56 instead. An address with bit 48 set and bits 63:49 clear is legal there but faults in four-level mode.
- R5: A walk that meets no absent entry issues exactly four memory reads in four-level mode and five in five-level mode.
- R6: The first entry address is the root base with bits 11:0 cleared, plus 8 times the index of the top level. The index of level L (1 = leaf table, 5 = top) is virtual address bits 12+9(L-1)+8 down to 12+9(L-1), so level 5 uses bits 56:48.
- R7: Entry bits 51:12 give the base of the next table. At level 1 they give the page frame, and `rsp_paddr` = {entry[51:12], vaddr[11:0]}. Entry bits 63:52 and 11:1 are ignored.
- R8: An entry with bit 0 clear ends the walk at once with `rsp_fault_np`=1, `rsp_fault_level` = that entry's level number, and `rsp_paddr`=0. No further read is issued.
- R9: `req_ready` falls in the cycle after acceptance. It stays low through the single cycle in which `rsp_valid` is high, and rises right after. No memory request is made while `req_ready` is high.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged `mem_req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration word; bit 12 selects five levels |
| long_mode | input | 1 | High while 64-bit operation is active; blocks configuration writes |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root table base address (bits 11:0 ignored) |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Fetched table entry |
| rsp_valid | output | 1 | One-cycle outcome strobe |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_fault_canon | output | 1 | Non-canonical address fault |
| rsp_fault_np | output | 1 | Absent entry fault |
| rsp_fault_level | output | 3 | Level of the absent entry |
| lvl5_mode | output | 1 | Current mode bit |

## Verification
Random addresses are drawn in both depths. Some are sign-extended from the top implemented bit and some have an upper bit flipped, so the canonical check has to separate the two widths. Addresses with bit 48 set and clear upper bits are legal in one mode and illegal in the other. Absent entries are placed at every level, from the top table to the leaf, so the reported level and the early stop are tested at each depth. Random stalls on the request ready and random response delays show whether the address holds and whether exactly one read is made per level. Entries carry junk in their unused bits, to catch a base formed from the wrong field.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned IDX_W   = 9;
  localparam int unsigned PG_BITS = 12;
  localparam int unsigned MAX_LVL = 5;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned SPAN_W  = PG_BITS + IDX_W * MAX_LVL;  // 57
  localparam int unsigned MODE_BIT = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk (
  input  logic [63:0] va,
  input  logic        five,
  output logic        ok
);
  localparam int unsigned LO4 = 47;
  localparam int unsigned LO5 = 56;

  logic ok4, ok5;
  assign ok4 = (&va[63:LO4]) | ~(|va[63:LO4]);
  assign ok5 = (&va[63:LO5]) | ~(|va[63:LO5]);
  assign ok  = five ? ok5 : ok4;
endmodule

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel
  import ptw_pkg::*;
#(
  parameter int unsigned NLVL = MAX_LVL
) (
  input  logic [IDX_W*NLVL-1:0] va_hi,
  input  logic [LVL_W-1:0]      lvl,
  output logic [IDX_W-1:0]      idx
);
  logic [IDX_W-1:0] tab [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_slice
    assign tab[g] = va_hi[IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NLVL; k++) begin
      if (lvl == LVL_W'(k + 1)) idx = tab[k];
    end
  end
endmodule

// File: rtl/pt_walk_unit.sv
module pt_walk_unit
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [63:0]     cfg_wdata,
  input  logic            long_mode,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [63:0]     req_root,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_fault_canon,
  output logic            rsp_fault_np,
  output logic [2:0]      rsp_fault_level,
  output logic            lvl5_mode
);
  localparam int unsigned FRM_W = PA_W - PG_BITS;

  walk_st_e             st_q;
  logic                 mode_q;
  logic [SPAN_W-1:0]    va_q;
  logic [LVL_W-1:0]     lvl_q;
  logic [PA_W-1:0]      base_q;
  logic [PA_W-1:0]      paddr_q;
  logic                 fcanon_q, fnp_q;
  logic [LVL_W-1:0]     flvl_q;
  logic                 canon_ok;
  logic [IDX_W-1:0]     idx;
  logic [FRM_W-1:0]     frame;

  ptw_canon_chk i_canon (
    .va   (req_vaddr),
    .five (mode_q),
    .ok   (canon_ok)
  );

  ptw_idx_sel #(.NLVL(MAX_LVL)) i_idx (
    .va_hi (va_q[SPAN_W-1:PG_BITS]),
    .lvl   (lvl_q),
    .idx   (idx)
  );

  assign frame        = mem_rsp_data[PA_W-1:PG_BITS];
  assign mem_req_addr = base_q + PA_W'({idx, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mode_q   <= 1'b0;
      va_q     <= '0;
      lvl_q    <= '0;
      base_q   <= '0;
      paddr_q  <= '0;
      fcanon_q <= 1'b0;
      fnp_q    <= 1'b0;
      flvl_q   <= '0;
    end else begin
      if (cfg_we && !long_mode) mode_q <= cfg_wdata[MODE_BIT];
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q     <= req_vaddr[SPAN_W-1:0];
          base_q   <= {req_root[PA_W-1:PG_BITS], {PG_BITS{1'b0}}};
          paddr_q  <= '0;
          fnp_q    <= 1'b0;
          flvl_q   <= '0;
          fcanon_q <= !canon_ok;
          lvl_q    <= mode_q ? LVL_W'(5) : LVL_W'(4);
          st_q     <= canon_ok ? ST_REQ : ST_DONE;
        end
        ST_REQ: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fnp_q  <= 1'b1;
            flvl_q <= lvl_q;
            st_q   <= ST_DONE;
          end else if (lvl_q == LVL_W'(1)) begin
            paddr_q <= {frame, va_q[PG_BITS-1:0]};
            st_q    <= ST_DONE;
          end else begin
            base_q <= {frame, {PG_BITS{1'b0}}};
            lvl_q  <= lvl_q - LVL_W'(1);
            st_q   <= ST_REQ;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready       = (st_q == ST_IDLE);
  assign mem_req_valid   = (st_q == ST_REQ);
  assign rsp_valid       = (st_q == ST_DONE);
  assign rsp_paddr       = paddr_q;
  assign rsp_fault_canon = fcanon_q;
  assign rsp_fault_np    = fnp_q;
  assign rsp_fault_level = flvl_q;
  assign lvl5_mode       = mode_q;

  logic spare_bits;
  assign spare_bits = ^{cfg_wdata[63:MODE_BIT+1], cfg_wdata[MODE_BIT-1:0],
                        req_root[63:PA_W], req_root[PG_BITS-1:0],
                        mem_rsp_data[63:PA_W], mem_rsp_data[PG_BITS-1:1]};
endmodule

// File: rtl/pt_walk_unit_chk.sv
module pt_walk_unit_chk #(
  parameter int unsigned PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            long_mode,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            rsp_valid,
  input logic            rsp_fault_canon,
  input logic            rsp_fault_np,
  input logic            lvl5_mode
);
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && long_mode |=> $stable(lvl5_mode)); // R2

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R9

  AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9

  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R9

  AST_SINGLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault_canon && rsp_fault_np)); // R8
endmodule

bind pt_walk_unit pt_walk_unit_chk #(.PA_W(PA_W)) i_chk (.*);

// File: tb/test_pt_walk_unit.sv
`timescale 1ns/1ps
module test_pt_walk_unit;
  localparam int PA_W = 52;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [63:0]     cfg_wdata = '0;
  logic            long_mode = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [63:0]     req_vaddr = '0;
  logic [63:0]     req_root = '0;
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic            rsp_fault_canon;
  logic            rsp_fault_np;
  logic [2:0]      rsp_fault_level;
  logic            lvl5_mode;

  pt_walk_unit #(.PA_W(PA_W)) i_pt_walk_unit (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int np_at = 99;
  int rd_idx = 0;
  logic cur_mode = 1'b0;
  logic [PA_W-1:0] exp_addr [5];
  int exp_reads;
  logic [PA_W-1:0] exp_paddr;
  logic exp_canon, exp_np;
  logic [2:0] exp_lvl;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] frame_of(input logic [PA_W-1:0] a);
    logic [63:0] m;
    m = {12'h0, a} * 64'h9E3779B97F4A7C15;
    return m[59:20];
  endfunction

  function automatic logic [63:0] entry_of(input logic [PA_W-1:0] a, input logic pres);
    return {12'hA5C, frame_of(a), 11'h2B6, pres};
  endfunction

  // expected walk, from the requirements
  task automatic model(input logic [63:0] va, input logic [63:0] root, input logic five, input int np);
    logic [PA_W-1:0] base;
    int top;
    logic ok;
    top = five ? 5 : 4;
    ok = five ? (&va[63:56] || !(|va[63:56])) : (&va[63:47] || !(|va[63:47]));
    exp_canon = !ok; exp_np = 1'b0; exp_lvl = 3'd0; exp_paddr = '0; exp_reads = 0;
    base = {root[PA_W-1:12], 12'h0};
    if (ok) begin
      for (int k = 0; k < top; k++) begin
        int l;
        logic [PA_W-1:0] a;
        l = top - k;
        a = base + PA_W'({va[12 + 9*(l-1) +: 9], 3'b000});
        exp_addr[k] = a;
        exp_reads = k + 1;
        if (k == np) begin
          exp_np = 1'b1; exp_lvl = 3'(l);
          break;
        end
        base = {frame_of(a), 12'h0};
        if (l == 1) exp_paddr = {frame_of(a), va[11:0]};
      end
    end
  endtask

  // memory model, all activity at the falling edge
  initial begin
    logic pend = 1'b0;
    int cnt = 0;
    logic [PA_W-1:0] held = '0;
    logic was_stalled = 1'b0;
    logic [PA_W-1:0] acc_addr = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = entry_of(acc_addr, (rd_idx - 1) != np_at);
          pend = 1'b0;
        end else cnt--;
      end
      if (was_stalled && rst_n) chk("R10", {12'h0, mem_req_addr}, {12'h0, held});
      mem_req_ready = ($urandom % 3) != 0;
      was_stalled = mem_req_valid && !mem_req_ready;
      held = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (rd_idx < 5) chk("R6", {12'h0, mem_req_addr}, {12'h0, exp_addr[rd_idx]});
        else chk("R8 extra read", 64'(rd_idx), 64'd4);
        acc_addr = mem_req_addr;
        rd_idx++;
        pend = 1'b1;
        cnt = $urandom % 4;
      end
    end
  end

  task automatic set_mode(input logic b, input logic lm);
    @(negedge clk);
    cfg_we = 1'b1; long_mode = lm;
    cfg_wdata = {$urandom, $urandom};
    cfg_wdata[12] = b;
    @(negedge clk);
    cfg_we = 1'b0; long_mode = 1'b0;
    if (!lm) cur_mode = b;
    chk(lm ? "R2" : "R1", 64'(lvl5_mode), 64'(cur_mode));
  endtask

  task automatic do_walk(input logic [63:0] va, input logic [63:0] root, input int np);
    int n;
    model(va, root, cur_mode, np);
    np_at = np;
    rd_idx = 0;
    @(negedge clk);
    n = 0;
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy", 64'(req_ready), 64'd0);
    n = 0;
    while (!rsp_valid && n < 500) begin @(negedge clk); n++; end
    chk("R9 rsp", 64'(rsp_valid), 64'd1);
    chk("R9 ready low at rsp", 64'(req_ready), 64'd0);
    chk(cur_mode ? "R4" : "R3", 64'(rsp_fault_canon), 64'(exp_canon));
    chk("R8 np", 64'(rsp_fault_np), 64'(exp_np));
    chk("R8 level", 64'(rsp_fault_level), 64'(exp_lvl));
    chk("R7", {12'h0, rsp_paddr}, {12'h0, exp_paddr});
    chk("R5", 64'(rd_idx), 64'(exp_reads));
    @(negedge clk);
    chk("R9 pulse", 64'(rsp_valid), 64'd0);
    chk("R9 ready again", 64'(req_ready), 64'd1);
  endtask

  function automatic logic [63:0] rand_va(input logic five, input logic bad_form);
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (five) v[63:57] = {7{v[56]}};
    else v[63:48] = {16{v[47]}};
    if (bad_form) v[62] = ~v[62];
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", 64'(lvl5_mode), 64'd0);
    chk("R9 reset ready", 64'(req_ready), 64'd1);
    chk("R9 reset rsp", 64'(rsp_valid), 64'd0);
    chk("R9 reset fetch", 64'(mem_req_valid), 64'd0);

    do_walk(64'h0000_7ABC_DEF1_2345, 64'h0000_0012_3456_7FFF, 99);  // R5 R6 R7
    do_walk(64'h0001_0000_0000_0123, 64'h0000_0000_0040_0000, 99);  // R3 fault
    set_mode(1'b1, 1'b0);                                           // R1
    do_walk(64'h0001_0000_0000_0123, 64'h0000_0000_0040_0000, 99);  // R4 legal
    do_walk(64'hFE00_0000_0000_0000, 64'h0000_0000_0040_0000, 99);  // R4 fault
    set_mode(1'b0, 1'b1);                                           // R2 ignored
    do_walk(64'h00AB_CDEF_0123_4567, 64'h0000_0ABC_0000_0000, 99);  // five reads
    do_walk(64'hFFFF_FFFF_FFFF_F000, 64'h0000_0000_0001_0000, 0);   // R8 top
    do_walk(64'h0012_3456_789A_BCDE, 64'h0000_0000_0001_0000, 4);   // R8 leaf
    set_mode(1'b0, 1'b0);
    do_walk(64'hFFFF_8000_0000_0FFF, 64'h0000_0000_0002_0000, 3);   // R8 leaf, 4-level
    do_walk(64'h0000_8000_0000_0000, 64'h0000_0000_0002_0000, 99);  // R3 fault

    for (int i = 0; i < 60; i++) begin
      if (($urandom % 5) == 0) set_mode(1'($urandom), 1'($urandom));
      do_walk(rand_va(cur_mode, ($urandom % 4) == 0),
              {$urandom, $urandom}, int'($urandom % 7));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule